// File: doc/BRIEF.md
# Clock-Stop SPI Master Serializer

This block is an SPI master that moves one 8-bit word per frame. The serial clock runs only while a word is being shifted and rests at the level set by the polarity input at all other times. Every word gets its own slave-select pulse. A word offered while the previous one is still in flight waits. It is then framed by a fresh falling edge of slave select after a high interval of at least one serial clock period. The two words never share one continuous low period.

A word enters on a valid/ready stream port. The master accepts it in any cycle in which `tx_valid_i` and `tx_ready_o` are both high. Back-pressure holds from the acceptance cycle until the slave-select gap that follows the word has fully elapsed. While `tx_ready_o` is low, the master ignores `tx_valid_i` and `tx_data_i`, so the sender may change them freely. The received word has no back-pressure: it appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse in the same cycle in which slave select returns high.

The divider input sets the serial clock period to `div_i + 1` system clocks, and `div_i` must be at least 1. Two timing modes exist. In the early mode, the first bit appears half a clock period before the first clock edge, so the slave-select fall is the only marker of the transfer's start. In the late mode, the first bit appears on the first clock edge. The master samples the divider and the mode once per word, at acceptance.

Top module: `spi_cs_master`

## Requirements
- R1: A word is framed by slave select low for exactly 9 serial periods of `div_i+1` system clocks each. The first of these periods is a one-bit lead-in delay with the clock idle. The remaining 8 periods carry data. Slave select goes low in the first cycle after acceptance.
- R2: After each word, slave select stays high for at least one full serial period. `tx_ready_o` is low from the acceptance cycle until that gap has elapsed. `tx_ready_o` is never high while slave select is low.
- R3: The serial clock idles at `cpol_i`. In each data period, the clock is at the inverse of `cpol_i` for the first `(div_i+1)/2` cycles (rounded down) and at `cpol_i` for the rest.
- R4: The word is transmitted most significant bit first.
- R5: In early mode (`early_i`=1), MOSI carries bit 7 from cycle `(div_i+1)/2` of the lead-in period onward. Each later bit appears at the second (trailing) clock edge of the preceding data period. The last bit is held until slave select rises.
- R6: In late mode (`early_i`=0), MOSI carries bit `7-k` for the whole of data period k, so it changes at the leading clock edge. MOSI is 0 whenever it carries no data bit.
- R7: MISO is received MSB first. In early mode it is sampled at the leading edge of each data period, in the cycle that starts that period. In late mode it is sampled at the trailing edge, in cycle `(div_i+1)/2` of the period.
- R8: `rx_valid_o` is a single-cycle pulse in the first cycle in which slave select is high after a word, and `rx_data_o` then holds the received word.
- R9: `div_i` and `early_i` are sampled at acceptance. Changing them while a word is in flight has no effect on that word.
- R10: During and after reset, slave select is high, the clock rests at `cpol_i`, `tx_ready_o` is 1 and `rx_valid_o` is 0.
- R11: A word is accepted only on a cycle with `tx_valid_i` and `tx_ready_o` both high. Valid and data presented while not ready are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial period minus one, in system clocks (at least 1) |
| early_i | input | 1 | 1: data half a period ahead of the first edge; 0: data on the first edge |
| cpol_i | input | 1 | Idle level of the serial clock |
| tx_data_i | input | WORD_W | Word to transmit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Master can accept a word |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Active-low slave select |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse marking a new received word |

## Verification
The hardest situation to reach is a second word that is already waiting while the first is still shifting or in its gap. The bench brings it about by holding `tx_valid_i` high straight into the next word, and by toggling valid, data, divider and mode at random during busy periods to show that none of them leaks into the word in flight. A second hard corner is a divider of 1 in late mode. There, the final trailing-edge sample lands in the same cycle as the capture of the received word, and the bench runs that setting with random MISO on every cycle.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP
  } cs_state_e;
endpackage

// File: rtl/spi_cs_phase.sv
// Position counter within one serial period of div+1 system clocks.
module spi_cs_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             at_zero_o,
  output logic             at_mid_o,
  output logic             second_half_o,
  output logic             slot_end_o
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [HW-1:0]    half;

  assign half          = HW'(({1'b0, div_i} + HW'(1)) >> 1);
  assign at_zero_o     = (cnt_q == '0);
  assign at_mid_o      = ({1'b0, cnt_q} == half);
  assign second_half_o = ({1'b0, cnt_q} >= half);
  assign slot_end_o    = run_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (slot_end_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_cs_txsel.sv
// Chooses the bit presented on MOSI from the period index and half.
module spi_cs_txsel #(
  parameter int WORD_W = 8
) (
  input  logic              in_lead_i,
  input  logic              in_shift_i,
  input  logic              early_i,
  input  logic              second_half_i,
  input  logic [(WORD_W>1 ? $clog2(WORD_W) : 1)-1:0] bidx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mosi_o
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0] idx;

  always_comb begin
    idx = LAST_BIT - bidx_i;
    if (early_i && second_half_i && (bidx_i != LAST_BIT)) idx = idx - BIT_W'(1);
    if (in_shift_i)     mosi_o = word_i[idx];
    else if (in_lead_i) mosi_o = early_i && second_half_i && word_i[WORD_W-1];
    else                mosi_o = 1'b0;
  end
endmodule

// File: rtl/spi_cs_rx.sv
// Receive shifter and word capture.
module spi_cs_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              capture_i,
  input  logic              miso_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], miso_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      if (sample_i) sh_q <= sh_next;
      // sample and capture coincide when the period is two clocks (R7)
      if (capture_i) rx_data_o <= sample_i ? sh_next : sh_q;
      rx_valid_o <= capture_i;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              early_i,
  input  logic              cpol_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_n_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  cs_state_e         st_q;
  logic [BIT_W-1:0]  bidx_q;
  logic [WORD_W-1:0] word_q;
  logic [DIV_W-1:0]  div_q;
  logic              early_q;

  logic accept, run;
  logic at_zero, at_mid, second_half, slot_end;
  logic in_lead, in_shift, rx_sample, rx_capture;

  assign accept   = tx_valid_i && (st_q == ST_IDLE);
  assign run      = (st_q != ST_IDLE);
  assign in_lead  = (st_q == ST_LEAD);
  assign in_shift = (st_q == ST_SHIFT);

  spi_cs_phase #(.DIV_W(DIV_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .div_i         (div_q),
    .at_zero_o     (at_zero),
    .at_mid_o      (at_mid),
    .second_half_o (second_half),
    .slot_end_o    (slot_end)
  );

  // Period sequencer: lead-in, WORD_W data periods, deasserted gap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bidx_q  <= '0;
      word_q  <= '0;
      div_q   <= '0;
      early_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_LEAD;
          word_q  <= tx_data_i;
          div_q   <= div_i;    // R9: timing fixed per word
          early_q <= early_i;
        end
        ST_LEAD: if (slot_end) begin
          st_q   <= ST_SHIFT;
          bidx_q <= '0;
        end
        ST_SHIFT: if (slot_end) begin
          if (bidx_q == LAST_BIT) st_q <= ST_GAP;
          else                    bidx_q <= bidx_q + BIT_W'(1);
        end
        ST_GAP: if (slot_end) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  spi_cs_txsel #(.WORD_W(WORD_W)) u_txsel (
    .in_lead_i     (in_lead),
    .in_shift_i    (in_shift),
    .early_i       (early_q),
    .second_half_i (second_half),
    .bidx_i        (bidx_q),
    .word_i        (word_q),
    .mosi_o        (mosi_o)
  );

  assign rx_sample  = in_shift && (early_q ? at_zero : at_mid);
  assign rx_capture = in_shift && slot_end && (bidx_q == LAST_BIT);

  spi_cs_rx #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (rx_sample),
    .capture_i  (rx_capture),
    .miso_i     (miso_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  assign tx_ready_o = (st_q == ST_IDLE);
  assign ss_n_o     = !(in_lead || in_shift);
  assign sclk_o     = cpol_i ^ (in_shift && !second_half);
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpol_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              sclk_o,
  input logic              ss_n_o,
  input logic              rx_valid_o,
  input logic [WORD_W-1:0] rx_data_o
);
  assert_ready_ss_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> ss_n_o);

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> (sclk_o == cpol_i));

  assert_accept_frames_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !ss_n_o);

  assert_ss_fall_needs_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n_o) |-> $past(tx_valid_i && tx_ready_o));

  assert_rxv_at_ss_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (ss_n_o && $past(!ss_n_o)));

  assert_rxv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  always_comb begin
    if (rst_n && rx_valid_o) assert_rxv_known_R8: assert (!$isunknown(rx_data_o));
  end
endmodule

bind spi_cs_master spi_cs_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpol_i     (cpol_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .sclk_o     (sclk_o),
  .ss_n_o     (ss_n_o),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o)
);

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
  localparam int W  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] div_i = 8'd3;
  logic          early_i = 1'b1;
  logic          cpol_i = 1'b0;
  logic [W-1:0]  tx_data_i = '0;
  logic          tx_valid_i = 1'b0;
  logic          tx_ready_o;
  logic          miso_i = 1'b0;
  logic          sclk_o, mosi_o, ss_n_o, rx_valid_o;
  logic [W-1:0]  rx_data_o;

  int vecs = 0;
  int fails = 0;

  // behavioural reference state
  bit       m_act = 0;
  int       m_t = 0, m_p = 1, m_h = 0;
  bit       m_early = 0;
  logic [7:0] m_word = '0, m_rx = '0;
  bit       acc = 0;

  always #2.5 clk = ~clk;

  spi_cs_master #(.WORD_W(W), .DIV_W(DW)) i_spi_cs_master (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .early_i(early_i), .cpol_i(cpol_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: advance the model across the coming edge, then compare
  task automatic step();
    int s, c;
    acc = 0;
    if (m_act) begin
      s = m_t / m_p; c = m_t % m_p;
      if (s >= 1 && s <= 8 && (m_early ? (c == 0) : (c == m_h)))
        m_rx = {m_rx[6:0], miso_i};                    // R7 sample point
      if (m_t == 10*m_p - 1) m_act = 0; else m_t++;
    end else if (tx_valid_i) begin                      // R11 acceptance
      acc = 1; m_act = 1; m_t = 0;
      m_p = int'(div_i) + 1; m_h = m_p / 2;
      m_early = early_i; m_word = tx_data_i;            // R9 latch
    end
    @(negedge clk);
    begin
      bit e_ss, e_sclk, e_mosi, e_rdy, e_rxv;
      e_ss = 1; e_sclk = cpol_i; e_mosi = 0; e_rdy = !m_act; e_rxv = 0;
      if (m_act) begin
        s = m_t / m_p; c = m_t % m_p;
        e_ss = !(s <= 8);
        if (s >= 1 && s <= 8) begin
          e_sclk = cpol_i ^ (c < m_h);
          if (!m_early || c < m_h) e_mosi = m_word[8-s];
          else e_mosi = (s < 8) ? m_word[7-s] : m_word[0];
        end else if (s == 0) e_mosi = m_early && (c >= m_h) && m_word[7];
        e_rxv = (s == 9 && c == 0);
      end
      chk(ss_n_o == e_ss, "R1", "ss_n", ss_n_o, e_ss);
      chk(sclk_o == e_sclk, "R3", "sclk", sclk_o, e_sclk);
      chk(mosi_o == e_mosi, m_early ? "R5" : "R6", "mosi (R4 msb first)", mosi_o, e_mosi);
      chk(tx_ready_o == e_rdy, "R2", "tx_ready", tx_ready_o, e_rdy);
      chk(rx_valid_o == e_rxv, "R8", "rx_valid", rx_valid_o, e_rxv);
      if (e_rxv) chk(rx_data_o == m_rx, "R7", "rx_data", rx_data_o, m_rx);
    end
    miso_i = 1'($urandom);
  endtask

  // send one word; optionally scramble inputs while busy (R9, R11)
  task automatic xfer(input logic [7:0] d, input int dv, input bit em, input bit noisy);
    div_i = DW'(dv); early_i = em; tx_data_i = d; tx_valid_i = 1;
    do step(); while (!acc);
    while (m_act) begin
      if (noisy) begin
        tx_valid_i = 1'($urandom); tx_data_i = 8'($urandom);
        div_i = DW'(1 + $urandom % 6); early_i = 1'($urandom);
      end else tx_valid_i = 0;
      step();
    end
    tx_valid_i = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(ss_n_o == 1, "R10", "ss_n in reset", ss_n_o, 1);
    chk(sclk_o == cpol_i, "R10", "sclk in reset", sclk_o, cpol_i);
    chk(tx_ready_o == 1, "R10", "ready in reset", tx_ready_o, 1);
    chk(rx_valid_o == 0, "R10", "rx_valid in reset", rx_valid_o, 0);
    rst_n = 1;
    repeat (2) step();
    // R2: two queued words, separate frames, early mode
    cpol_i = 0;
    xfer(8'h60, 3, 1, 0);
    xfer(8'hFE, 3, 1, 0);
    // late mode, two-clock period, cpol 1; R9/R11 noise while busy
    cpol_i = 1;
    xfer(8'hA5, 1, 0, 1);
    xfer(8'h3C, 1, 0, 0);
    // odd period, early
    xfer(8'h81, 4, 1, 1);
    cpol_i = 0;
    xfer(8'h00, 2, 0, 0);
    xfer(8'hFF, 2, 0, 1);
    repeat (5) step();
    xfer(8'h5A, 26, 1, 0);
    for (int i = 0; i < 12; i++) begin
      cpol_i = 1'($urandom);
      xfer(8'($urandom), 1 + $urandom % 7, 1'($urandom), 1'($urandom));
      repeat ($urandom % 3) step();
    end
    repeat (4) step();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule